// File: doc/BRIEF.md
# Sector Cache With Per-Sub-Block Valid Bits

This block is a read-only, direct-mapped cache controller whose lines are divided into sub-blocks. Each line stores one tag, but every sub-block carries its own valid flag. A lookup succeeds only when the stored tag equals the request's tag and the flag of the addressed sub-block is set. Only the missing sub-block is fetched from memory on a miss, never the whole line.

When the tag of a missing request differs from the stored tag, the line is taken over by the new tag. All of its flags are cleared and only the freshly fetched sub-block is marked present. When the tag already matches, the line keeps its tag and its other flags, and only the new sub-block is added. The CPU side offers a read request with a ready flag, a hit pulse and returned data. The memory side issues one request per miss and takes one sub-block per response beat. After the fill, the stalled request is looked up again and completes as a hit.

Top module: `sector_cache`

## Requirements
- R1: An active-low reset clears every valid flag of every line. After reset the cache is ready, `cpu_hit_o` and `mem_req_o` are low, and the first read of any address misses, including one whose tag equals the reset tag value of zero.
- R2: The address splits into three fields. Bits [SUB_IDX_W-1:0] select the sub-block. The next IDX_W bits select one of 2^IDX_W lines. The remaining upper bits form the tag. Each (line, sub-block) slot returns the word last filled for that address.
- R3: A hit pulses `cpu_hit_o` high for one cycle, in the cycle after the request is accepted. It occurs only when the stored tag matches and the addressed sub-block's flag is set. `cpu_data_o` then equals the memory word of that address, and the cache is ready again in the following cycle.
- R4: A request whose tag matches but whose sub-block flag is clear is a miss. Only that sub-block is requested, with `mem_addr_o` equal to the full request address. The line's other present sub-blocks stay present and later read as hits.
- R5: A miss with a different tag overwrites the line's tag and clears the flags of all its other sub-blocks. Later reads of the old tag, or of other sub-blocks of the new tag, miss.
- R6: On a miss, `mem_req_o` rises two cycles after acceptance. It stays high with a stable `mem_addr_o` until `mem_valid_i` is sampled high. The replayed request hits two cycles after that beat. `cpu_ready_o` stays low from acceptance until the replayed hit.
- R7: Each miss takes exactly one response beat. `mem_req_o` is low in the cycle after the beat.
- R8: `cpu_req_i` and `cpu_addr_i` are ignored while `cpu_ready_o` is low. No extra lookup follows the replayed hit, and that hit returns the original address's data.
- R9: `mem_valid_i` is ignored when no fetch is pending. It starts no fill, and cached contents stay unchanged.
- R10: `cpu_ready_o` is high only when the cache is idle. A request is accepted on a clock edge where `cpu_req_i` and `cpu_ready_o` are both high, and `cpu_ready_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU read request |
| cpu_addr_i | input | ADDR_W | CPU read address |
| cpu_ready_o | output | 1 | Cache idle, request can be accepted |
| cpu_hit_o | output | 1 | One-cycle pulse: read data valid |
| cpu_data_o | output | DATA_W | Read data, valid with cpu_hit_o |
| mem_req_o | output | 1 | Sub-block fetch request, held until response |
| mem_addr_o | output | ADDR_W | Address of the sub-block being fetched |
| mem_valid_i | input | 1 | Memory response beat |
| mem_data_i | input | DATA_W | Fetched sub-block data |

## Verification
A hit is due one cycle after the accepting edge. A miss raises the memory request one cycle later still. The replayed hit follows two cycles after the response beat, and the ready flag returns in the cycle after any hit. The bench runs a behavioural model of tags and sub-block flags and steps it one clock at a time. It samples every output at the falling edge and compares it with the model in each of those cycles. The response latency, busy-time request noise and stray response beats are varied, so each of these offsets is checked across several latencies.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_LOOKUP = 2'd1,
    SC_FETCH  = 2'd2,
    SC_FILL   = 2'd3
  } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
  parameter int TAG_W     = 11,
  parameter int IDX_W     = 3,
  parameter int SUB_IDX_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     rd_idx_i,
  output logic [TAG_W-1:0]     rd_tag_o,
  output logic [(1<<SUB_IDX_W)-1:0] rd_vld_o,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [TAG_W-1:0]     wr_tag_i,
  input  logic [SUB_IDX_W-1:0] wr_sub_i
);
  localparam int LINES = 1 << IDX_W;
  localparam int SUBS  = 1 << SUB_IDX_W;

  logic [TAG_W-1:0] tag_arr [LINES];
  logic [SUBS-1:0]  vld_arr [LINES];
  logic [SUBS-1:0]  sub_onehot;

  assign sub_onehot = SUBS'(1) << wr_sub_i;

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [TAG_W-1:0] tag_q;
    logic [SUBS-1:0]  vld_q;
    logic             sel;

    assign sel = wr_en_i && (wr_idx_i == IDX_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        vld_q <= '0;
      end else if (sel) begin
        tag_q <= wr_tag_i;
        // new owner drops the old sub-blocks
        vld_q <= ((tag_q == wr_tag_i) ? vld_q : '0) | sub_onehot;
      end
    end

    assign tag_arr[l] = tag_q;
    assign vld_arr[l] = vld_q;
  end

  assign rd_tag_o = tag_arr[rd_idx_i];
  assign rd_vld_o = vld_arr[rd_idx_i];
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3,
  parameter int SUB_IDX_W = 2
) (
  input  logic                 clk_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  logic [SUB_IDX_W-1:0] rd_sub_i,
  output logic [DATA_W-1:0]    rd_data_o,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [SUB_IDX_W-1:0] wr_sub_i,
  input  logic [DATA_W-1:0]    wr_data_i
);
  localparam int SLOTS = 1 << (IDX_W + SUB_IDX_W);

  logic [DATA_W-1:0] mem_q [SLOTS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_idx_i, wr_sub_i}] <= wr_data_i;
  end

  assign rd_data_o = mem_q[{rd_idx_i, rd_sub_i}];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ready_o,
  output logic              hit_o,
  input  logic              lookup_hit_i,
  output logic              mem_req_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fill_en_o,
  output logic [DATA_W-1:0] fill_data_o
);
  sc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] fill_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SC_IDLE:   if (cpu_req_i) state_d = SC_LOOKUP;
      SC_LOOKUP: state_d = lookup_hit_i ? SC_IDLE : SC_FETCH;
      SC_FETCH:  if (mem_valid_i) state_d = SC_FILL;
      SC_FILL:   state_d = SC_LOOKUP;  // replay
      default:   state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SC_IDLE;
      addr_q  <= '0;
      fill_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SC_IDLE && cpu_req_i) addr_q <= cpu_addr_i;
      if (state_q == SC_FETCH && mem_valid_i) fill_q <= mem_data_i;
    end
  end

  assign cpu_ready_o = (state_q == SC_IDLE);
  assign hit_o       = (state_q == SC_LOOKUP) && lookup_hit_i;
  assign mem_req_o   = (state_q == SC_FETCH);
  assign fill_en_o   = (state_q == SC_FILL);
  assign addr_o      = addr_q;
  assign fill_data_o = fill_q;
endmodule

// File: rtl/sector_cache.sv
module sector_cache #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 3,
  parameter int SUB_IDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic              cpu_ready_o,
  output logic              cpu_hit_o,
  output logic [DATA_W-1:0] cpu_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i
);
  localparam int TAG_W = ADDR_W - IDX_W - SUB_IDX_W;
  localparam int SUBS  = 1 << SUB_IDX_W;

  logic [ADDR_W-1:0]    addr;
  logic [TAG_W-1:0]     a_tag, rd_tag;
  logic [IDX_W-1:0]     a_idx;
  logic [SUB_IDX_W-1:0] a_sub;
  logic [SUBS-1:0]      rd_vld;
  logic                 lookup_hit, fill_en;
  logic [DATA_W-1:0]    fill_data;

  assign a_sub = addr[SUB_IDX_W-1:0];
  assign a_idx = addr[SUB_IDX_W +: IDX_W];
  assign a_tag = addr[ADDR_W-1 -: TAG_W];
  assign lookup_hit = (rd_tag == a_tag) && rd_vld[a_sub];

  sc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk_i, .rst_ni, .cpu_req_i, .cpu_addr_i, .cpu_ready_o,
    .hit_o(cpu_hit_o), .lookup_hit_i(lookup_hit), .mem_req_o,
    .mem_valid_i, .mem_data_i, .addr_o(addr), .fill_en_o(fill_en),
    .fill_data_o(fill_data)
  );

  sc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .SUB_IDX_W(SUB_IDX_W)) i_tags (
    .clk_i, .rst_ni, .rd_idx_i(a_idx), .rd_tag_o(rd_tag), .rd_vld_o(rd_vld),
    .wr_en_i(fill_en), .wr_idx_i(a_idx), .wr_tag_i(a_tag), .wr_sub_i(a_sub)
  );

  sc_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SUB_IDX_W(SUB_IDX_W)) i_data (
    .clk_i, .rd_idx_i(a_idx), .rd_sub_i(a_sub), .rd_data_o(cpu_data_o),
    .wr_en_i(fill_en), .wr_idx_i(a_idx), .wr_sub_i(a_sub), .wr_data_i(fill_data)
  );

  assign mem_addr_o = addr;
endmodule

// File: rtl/sector_cache_chk.sv
module sector_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_ready_o,
  input logic              cpu_hit_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_valid_i,
  input logic [DATA_W-1:0] mem_data_i
);
  // R10
  accept_drops_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && cpu_ready_o) |=> !cpu_ready_o);
  // R6
  fetch_blocks_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !cpu_ready_o);
  // R6
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R7
  single_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> !mem_req_o);
  // R6
  replay_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |-> ##2 cpu_hit_o);
  // R3
  hit_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |=> cpu_ready_o);
  // R3
  hit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> (!cpu_ready_o && !mem_req_o));
  // R9
  stray_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && mem_valid_i) |=> !mem_req_o);
endmodule

bind sector_cache sector_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_req_i(cpu_req_i), .cpu_ready_o(cpu_ready_o),
  .cpu_hit_o(cpu_hit_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_valid_i(mem_valid_i), .mem_data_i(mem_data_i)
);

// File: tb/test_sector_cache.sv
`timescale 1ns/1ps
module test_sector_cache;
  localparam int ADDR_W = 16, DATA_W = 32, IDX_W = 3, SUB_IDX_W = 2;
  localparam int LINES = 1 << IDX_W;
  localparam int SUBS  = 1 << SUB_IDX_W;
  localparam int OFS   = IDX_W + SUB_IDX_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_ni;
  logic              cpu_req_i;
  logic [ADDR_W-1:0] cpu_addr_i;
  logic              cpu_ready_o, cpu_hit_o;
  logic [DATA_W-1:0] cpu_data_o;
  logic              mem_req_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_valid_i;
  logic [DATA_W-1:0] mem_data_i;

  sector_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SUB_IDX_W(SUB_IDX_W))
  i_sector_cache (
    .clk_i(clk), .rst_ni, .cpu_req_i, .cpu_addr_i, .cpu_ready_o, .cpu_hit_o,
    .cpu_data_o, .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_data_i
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;
  int ref_tag [LINES];
  bit ref_vld [LINES][SUBS];

  function automatic logic [DATA_W-1:0] mem_word(logic [ADDR_W-1:0] a);
    return {a ^ 16'h3C5A, ~a};
  endfunction

  function automatic logic [ADDR_W-1:0] mk(int t, int i, int s);
    return ADDR_W'((t << OFS) | (i << SUB_IDX_W) | s);
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [DATA_W-1:0] act,
                     logic [DATA_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // starts and ends at a falling edge with the cache idle
  task automatic rd(logic [ADDR_W-1:0] a, int lat, bit noise);
    int t = int'(a) >> OFS;
    int i = (int'(a) >> SUB_IDX_W) & (LINES - 1);
    int s = int'(a) & (SUBS - 1);
    bit exp_hit = ref_vld[i][s] && (ref_tag[i] == t);
    chk(cpu_ready_o === 1'b1, "R10", "ready before request", 32'(cpu_ready_o), 1);
    cpu_req_i = 1'b1; cpu_addr_i = a;
    @(negedge clk);
    cpu_req_i = 1'b0; cpu_addr_i = ~a;
    chk(cpu_ready_o === 1'b0, "R10", "ready after accept", 32'(cpu_ready_o), 0);
    chk(cpu_hit_o === exp_hit, exp_hit ? "R3" : "R4", "lookup hit", 32'(cpu_hit_o), 32'(exp_hit));
    chk(mem_req_o === 1'b0, "R6", "no request in lookup", 32'(mem_req_o), 0);
    if (exp_hit)
      chk(cpu_data_o === mem_word(a), "R2", "hit data", cpu_data_o, mem_word(a));
    else begin
      @(negedge clk);
      if (noise) begin cpu_req_i = 1'b1; cpu_addr_i = a ^ 16'h0155; end
      chk(mem_req_o === 1'b1, "R6", "fetch request", 32'(mem_req_o), 1);
      chk(mem_addr_o === a, "R4", "sub-block address", 32'(mem_addr_o), 32'(a));
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        chk(mem_req_o === 1'b1 && mem_addr_o === a, "R6", "request held",
            32'(mem_addr_o), 32'(a));
        chk(cpu_ready_o === 1'b0, "R8", "busy while fetching", 32'(cpu_ready_o), 0);
      end
      mem_valid_i = 1'b1; mem_data_i = mem_word(a);
      @(negedge clk);
      mem_valid_i = 1'b0; mem_data_i = 32'hDEAD_BEEF; cpu_req_i = 1'b0;
      chk(mem_req_o === 1'b0, "R7", "request drops after beat", 32'(mem_req_o), 0);
      chk(cpu_ready_o === 1'b0 && cpu_hit_o === 1'b0, "R6", "fill cycle quiet",
          32'(cpu_hit_o), 0);
      @(negedge clk);
      chk(cpu_hit_o === 1'b1, "R6", "replayed hit", 32'(cpu_hit_o), 1);
      chk(cpu_data_o === mem_word(a), "R8", "replay data", cpu_data_o, mem_word(a));
      if (ref_tag[i] != t) begin
        ref_tag[i] = t;
        for (int k = 0; k < SUBS; k++) ref_vld[i][k] = 1'b0;
      end
      ref_vld[i][s] = 1'b1;
    end
    @(negedge clk);
    chk(cpu_ready_o === 1'b1 && cpu_hit_o === 1'b0, "R10", "idle after hit",
        32'(cpu_hit_o), 0);
  endtask

  task automatic stray();
    mem_valid_i = 1'b1; mem_data_i = 32'hBAD0_BAD0;
    @(negedge clk);
    mem_valid_i = 1'b0;
    chk(mem_req_o === 1'b0 && cpu_ready_o === 1'b1, "R9", "stray beat ignored",
        32'(mem_req_o), 0);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int l = 0; l < LINES; l++) begin
      ref_tag[l] = 0;
      for (int s = 0; s < SUBS; s++) ref_vld[l][s] = 1'b0;
    end
    rst_ni = 1'b0; cpu_req_i = 1'b0; cpu_addr_i = '0;
    mem_valid_i = 1'b0; mem_data_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cpu_ready_o === 1'b1 && cpu_hit_o === 1'b0 && mem_req_o === 1'b0, "R1",
        "reset outputs", {cpu_ready_o, cpu_hit_o, mem_req_o}, 3'b100);
    rd(mk(0, 0, 0), 1, 0);  // R1: reset tag value still misses
    rd(mk(5, 2, 1), 2, 0);
    rd(mk(5, 2, 1), 0, 0);  // R3
    rd(mk(5, 2, 3), 0, 1);  // R4 partial fill, R8 noise
    rd(mk(5, 2, 1), 0, 0);  // R4 retained
    rd(mk(9, 2, 0), 1, 1);  // R5 takeover
    rd(mk(5, 2, 3), 3, 0);  // R5 invalidated
    rd(mk(9, 2, 0), 0, 0);
    rd(mk(5, 7, 2), 2, 0);  // R2 other line
    rd(mk(5, 0, 0), 0, 0);
    rd(mk(0, 0, 0), 0, 0);
    stray();                // R9
    rd(mk(5, 7, 2), 0, 0);
    rd(mk(3, 7, 2), 1, 0);
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd(mk(int'(lfsr[1:0]) % 3, int'(lfsr[4:2]), int'(lfsr[6:5])),
         int'(lfsr[9:8]), lfsr[10]);
      if (lfsr[11]) stray();
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule